// File: doc/BRIEF.md
# Serial-Read Switch Bank Monitor

This block watches a bank of switch inputs (16 by default, 8 in the narrow build) and lets a controller read them through a 4-wire SPI slave port. When chip select falls, the block copies the live inputs into a snapshot register. The first SCLK rising edge of the frame loads that snapshot into a shift register. The bits then leave on the serial output MSB first, one per rising edge. Serial input bits are taken on falling edges and enter behind the snapshot, so the output of one block can drive the serial input of the next and a single frame reads a whole chain.

An active-low interrupt is pulled whenever any live input differs from the snapshot. It lets go by itself when the inputs return to the captured values, or when a new chip-select fall takes a fresh snapshot. An enable input can hold the interrupt released. Both open-drain outputs appear as pull enables, so they can be resolved with a pull-up outside the block. All SPI pins and switch inputs pass through two-flop synchronizers into the system clock. That clock must run at least four times faster than SCLK, and SCLK must be low whenever chip select changes.

Top module: `switch_monitor_spi`

## Requirements
- R1: While `rst` is high the snapshot and shift registers clear to zero and `sdout_oe` and `irq_pull` stay low; after reset, inputs that are not all zero pull the interrupt because they differ from the zeroed snapshot.
- R2: A falling `cs_n` copies the synchronized inputs into the snapshot; input changes later in the frame do not alter the bits read out, and a difference present before the fall no longer pulls the interrupt.
- R3: The first SCLK rising edge after `cs_n` falls loads the shift register from the snapshot, and input bit N-1 appears on `sdout_d`.
- R4: Each later SCLK rising edge in the frame shifts by one place, so input bits N-1 down to 0 appear on `sdout_d` in that order.
- R5: `sdin` is sampled on each SCLK falling edge and enters at the shift register's low end; the first bit sent appears on `sdout_d` after rising edge N+1.
- R6: `sdout_oe` is high while `cs_n` is low and low while `cs_n` is high.
- R7: With `irq_en` high, `irq_pull` is high exactly when some synchronized input differs from its snapshot bit, and it drops once they match again.
- R8: With `irq_en` low, `irq_pull` is low whatever the inputs.
- R9: Two instances sharing `cs_n` and SCLK, with the first one's serial output feeding the second one's `sdin`, read as one chain of the second's bits then the first's; their interrupt pulls combine as a wired-AND on one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in, sampled on SCLK fall |
| sw_in | input | WIDTH | Switch inputs, bit WIDTH-1 read first |
| irq_en | input | 1 | Interrupt enable, high allows pulling |
| sdout_d | output | 1 | Serial data out value |
| sdout_oe | output | 1 | Serial data out drive enable |
| irq_pull | output | 1 | Interrupt pull-low enable |

## Verification
The bench builds two instances, one with WIDTH 16 and one with WIDTH 8, and chains them. The wide instance covers the default snapshot, the shift order and serial pass-through. Chaining the narrow one behind it shows that the two widths work together in one 24-bit read frame and share one interrupt line. Frames that change inputs between the chip-select fall and the first SCLK edge show that reads come from the snapshot and not from the live pins.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef struct packed {
        logic cs_fall;
        logic selected;
        logic sck_rise;
        logic sck_fall;
    } spi_evt_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_SHIFT = 2'd2
    } frame_phase_e;

    function automatic spi_evt_t decode_evt(input logic cs_now, input logic cs_prev,
                                            input logic sck_now, input logic sck_prev);
        spi_evt_t e;
        e.cs_fall  = cs_prev & ~cs_now;
        e.selected = ~cs_now;
        e.sck_rise = ~cs_now & sck_now & ~sck_prev;
        e.sck_fall = ~cs_now & ~sck_now & sck_prev;
        return e;
    endfunction

endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpi_shifter.sv
module gpi_shifter
    import gpi_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  spi_evt_t     evt,
    input  logic [N-1:0] sw_s,
    input  logic         sdin_s,
    output logic [N-1:0] snapshot,
    output logic         msb_out
);
    frame_phase_e phase;
    logic [N-1:0] shreg;
    logic         sin_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            snapshot <= '0;
            shreg    <= '0;
            sin_hold <= 1'b0;
        end else if (evt.cs_fall) begin
            snapshot <= sw_s;
            phase    <= PH_ARMED;
        end else if (!evt.selected) begin
            phase <= PH_IDLE;
        end else begin
            if (evt.sck_rise) begin
                if (phase == PH_ARMED) begin
                    shreg <= snapshot;
                    phase <= PH_SHIFT;
                end else if (phase == PH_SHIFT) begin
                    shreg <= {shreg[N-2:0], sin_hold};
                end
            end
            if (evt.sck_fall && phase == PH_SHIFT) begin
                sin_hold <= sdin_s;
            end
        end
    end

    assign msb_out = shreg[N-1];

    assert_snapshot_R2: assert property (@(posedge clk) disable iff (rst)
        evt.cs_fall |=> snapshot == $past(sw_s));

    assert_first_load_R3: assert property (@(posedge clk) disable iff (rst)
        (!evt.cs_fall && evt.sck_rise && phase == PH_ARMED) |=> shreg == $past(snapshot));

    assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!evt.cs_fall && evt.sck_rise && phase == PH_SHIFT)
            |=> shreg[N-1:1] == $past(shreg[N-2:0]));

    assert_sdin_take_R5: assert property (@(posedge clk) disable iff (rst)
        (!evt.cs_fall && evt.sck_fall && phase == PH_SHIFT) |=> sin_hold == $past(sdin_s));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!evt.selected && !evt.cs_fall) |=> $stable(shreg));
endmodule

// File: rtl/gpi_irq.sv
module gpi_irq #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sw_s,
    input  logic [N-1:0] snapshot,
    input  logic         irq_en,
    output logic         irq_pull
);
    logic [N-1:0] diff;
    logic         any_diff;

    assign diff     = sw_s ^ snapshot;
    assign any_diff = |diff;
    assign irq_pull = irq_en & any_diff & ~rst;

    assert_match_release_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_s == snapshot) |-> !irq_pull);

    assert_enable_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_pull);
endmodule

// File: rtl/switch_monitor_spi.sv
module switch_monitor_spi
    import gpi_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdin,
    input  logic [WIDTH-1:0] sw_in,
    input  logic             irq_en,
    output logic             sdout_d,
    output logic             sdout_oe,
    output logic             irq_pull
);
    logic             cs_s, sck_s, sdin_s;
    logic [WIDTH-1:0] sw_s;
    logic             cs_prev, sck_prev;
    logic [WIDTH-1:0] snapshot;
    spi_evt_t         evt;

    gpi_sync #(.W(1), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_s));
    gpi_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sck (
        .clk(clk), .rst(rst), .d(sclk), .q(sck_s));
    gpi_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sdin (
        .clk(clk), .rst(rst), .d(sdin), .q(sdin_s));
    gpi_sync #(.W(WIDTH), .RST_VAL(1'b0)) u_sync_sw (
        .clk(clk), .rst(rst), .d(sw_in), .q(sw_s));

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_prev  <= cs_s;
            sck_prev <= sck_s;
        end
    end

    assign evt = decode_evt(cs_s, cs_prev, sck_s, sck_prev);

    gpi_shifter #(.N(WIDTH)) u_shifter (
        .clk(clk), .rst(rst), .evt(evt), .sw_s(sw_s), .sdin_s(sdin_s),
        .snapshot(snapshot), .msb_out(sdout_d));

    gpi_irq #(.N(WIDTH)) u_irq (
        .clk(clk), .rst(rst), .sw_s(sw_s), .snapshot(snapshot),
        .irq_en(irq_en), .irq_pull(irq_pull));

    assign sdout_oe = ~cs_s & ~rst;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> (!sdout_oe && !irq_pull));
endmodule

// File: tb/test_switch_monitor_spi.sv
module test_switch_monitor_spi;
    localparam int NA = 16;
    localparam int NB = 8;
    localparam int H  = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0, irq_en = 1'b1;
    logic [NA-1:0] sw_a = '0;
    logic [NB-1:0] sw_b = '0;
    logic a_d, a_oe, a_pull, b_d, b_oe, b_pull, b_sdin, irq_line;

    switch_monitor_spi #(.WIDTH(NA)) i_switch_monitor_spi (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(sdin), .sw_in(sw_a),
        .irq_en(irq_en), .sdout_d(a_d), .sdout_oe(a_oe), .irq_pull(a_pull));

    assign b_sdin = a_oe ? a_d : 1'b0;

    switch_monitor_spi #(.WIDTH(NB)) i_chain (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdin(b_sdin), .sw_in(sw_b),
        .irq_en(irq_en), .sdout_d(b_d), .sdout_oe(b_oe), .irq_pull(b_pull));

    assign irq_line = ~(a_pull | b_pull);

    typedef struct {
        int    kind;
        string tag;
        logic  exp;
    } item_t;

    item_t q[$];
    event  sample_ev;
    int    checks = 0, failures = 0;
    bit    done = 0;

    initial forever begin
        @(sample_ev);
        while (q.size() > 0) begin
            item_t it;
            logic  act;
            it = q.pop_front();
            case (it.kind)
                0: act = a_d;
                1: act = b_d;
                2: act = irq_line;
                3: act = a_oe;
                default: act = b_oe;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%b expected=%b", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(int kind, string tag, logic exp);
        item_t it;
        it.kind = kind; it.tag = tag; it.exp = exp;
        q.push_back(it);
        -> sample_ev;
        #0;
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wait_clk(H);
        push(3, "R6", 1'b1);
    endtask

    task automatic cs_high();
        cs_n = 1'b1;
        wait_clk(H);
        push(3, "R6", 1'b0);
    endtask

    task automatic bits(int nbits, logic [63:0] expv, logic [63:0] dinv, int kind, string tag);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sdin = dinv[nbits-1-i];
            wait_clk(H);
            push(kind, (i == 0) ? "R3" : tag, expv[nbits-1-i]);
            sclk = 1'b0;
            wait_clk(H);
        end
        sdin = 1'b0;
    endtask

    initial begin
        wait_clk(4);
        push(3, "R1", 1'b0);
        push(2, "R1", 1'b1);
        sw_a = 16'hA5C3;
        wait_clk(4);
        push(2, "R1", 1'b1);
        rst = 1'b0;
        wait_clk(6);
        push(2, "R1", 1'b0);

        cs_low();
        push(2, "R2", 1'b1);
        bits(NA, 64'hA5C3, 64'h0, 0, "R4");
        cs_high();

        cs_low();
        bits(24, {40'h0, 16'hA5C3, 8'h5A}, {40'h0, 8'h5A, 16'h0}, 0, "R5");
        cs_high();

        sw_a = 16'h0F0F;
        wait_clk(4);
        push(2, "R7", 1'b0);
        cs_low();
        sw_a = 16'hFFFF;
        wait_clk(4);
        push(2, "R7", 1'b0);
        bits(NA, 64'h0F0F, 64'h0, 0, "R2");
        sw_a = 16'h0F0F;
        wait_clk(4);
        push(2, "R7", 1'b1);
        cs_high();

        irq_en = 1'b0;
        sw_a = 16'h1234;
        wait_clk(4);
        push(2, "R8", 1'b1);
        irq_en = 1'b1;
        wait_clk(2);
        push(2, "R7", 1'b0);

        sw_b = 8'h3C;
        wait_clk(4);
        push(2, "R9", 1'b0);
        cs_low();
        push(4, "R9", 1'b1);
        bits(32, {32'h0, 8'h3C, 16'h1234, 8'hC7}, {32'h0, 8'hC7, 24'h0}, 1, "R9");
        cs_high();
        push(2, "R9", 1'b1);
        sw_b = 8'h3D;
        wait_clk(4);
        push(2, "R9", 1'b0);
        sw_b = 8'h3C;
        wait_clk(4);
        push(2, "R9", 1'b1);

        wait_clk(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog req=all actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule